// File: doc/BRIEF.md
# Test Interrupt Generator

This is a small memory-mapped peripheral that lets test software raise or drop the four platform interrupt lines of a single hart. These lines are machine external, machine software, supervisor external and supervisor software. The block has one single-beat request port with a valid strobe, a byte address, a write enable, write data and an access size. One cycle after each request it returns read data and an access-fault flag.

The register window is 32 bytes. Offset 0 holds a read-only identification word. Its upper half is the major number and its lower half is the minor number. Offset 4 is a control word that always reads as zero. A write to the control word names a group of lines, and one direction bit says whether that group is raised or dropped. The block faults on the following:
- any access that is not a naturally aligned full word;
- any touch of the unused upper part of the window;
- any control write that has an undefined bit set.

A faulting access changes no interrupt state.

Top module: `irq_test_gen`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and all four interrupt outputs are 0.
- R2: A word read at offset 0 returns 0x00010000 (major number 1 in bits 31:16, minor number 0 in bits 15:0) with `rsp_fault` = 0.
- R3: A word read at offset 4 returns 0 with `rsp_fault` = 0.
- R4: A word write at offset 0 completes without fault and changes no interrupt output.
- R5: A fault-free control write with bit 31 = 1 raises each selected line. The selects are bit 1 for supervisor software, bit 3 for machine software, bit 9 for supervisor external and bit 11 for machine external. All selected lines change in the same cycle.
- R6: A fault-free control write with bit 31 = 0 drops each selected line.
- R7: On a control write, lines whose select bit is 0 keep their value.
- R8: A control write with any bit set outside {1, 3, 9, 11, 31} faults and leaves every interrupt output unchanged.
- R9: An access whose `req_size` is not 2 faults. The size code is log2 of the byte count: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Such an access changes no state.
- R10: An access whose address bits 1:0 are not 00 faults and changes no state.
- R11: An access at offsets 8 to 31 faults, returns read data 0 and changes no state.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Read data and the fault flag are valid in that cycle. Interrupt outputs change only in the cycle after an accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_addr | input | AW (5) | Byte offset within the window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | log2 of access byte count |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data, 0 for writes and faults |
| rsp_fault | output | 1 | Access fault |
| irq_mext | output | 1 | Machine external interrupt level |
| irq_msw | output | 1 | Machine software interrupt level |
| irq_sext | output | 1 | Supervisor external interrupt level |
| irq_ssw | output | 1 | Supervisor software interrupt level |

## Verification
The hardest case to reach is a write that is legal in every respect but one while the lines already hold a mixed pattern. In that case an error in the fault logic shows only as a single line flipping that should have held. The bench first drives all sixteen select groups in both directions, so that the lines pass through many mixed states. It then sweeps every reserved control bit, and every address and size pair, with a write that would raise all four lines. After each step it compares the lines against a model that changes only on a fault-free control write.

// File: rtl/irq_test_gen.sv
module irq_test_gen #(
  parameter int          AW      = 5,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [31:0]   req_wdata,
  input  logic [1:0]    req_size,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_fault,
  output logic          irq_mext,
  output logic          irq_msw,
  output logic          irq_sext,
  output logic          irq_ssw
);
  localparam logic [31:0] LEGAL_BITS = 32'h8000_0A0A;
  localparam logic [1:0]  WORD_SIZE  = 2'd2;

  logic [3:0] lines;

  wire word_ok  = (req_size == WORD_SIZE) && (req_addr[1:0] == 2'b00);
  wire in_regs  = (req_addr[AW-1:3] == '0);
  wire is_ctrl  = req_addr[2];
  wire bits_ok  = !(req_we && is_ctrl) || ((req_wdata & ~LEGAL_BITS) == 32'h0);
  wire acc_ok   = word_ok && in_regs && bits_ok;
  wire do_ctrl  = req_valid && req_we && is_ctrl && acc_ok;
  wire do_ver   = req_valid && !req_we && !is_ctrl && acc_ok;
  wire [3:0] sel = {req_wdata[11], req_wdata[9], req_wdata[3], req_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines     <= 4'h0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !acc_ok;
      rsp_rdata <= do_ver ? VERSION : 32'h0;
      if (do_ctrl)
        lines <= req_wdata[31] ? (lines | sel) : (lines & ~sel);
    end
  end

  assign {irq_mext, irq_sext, irq_msw, irq_ssw} = lines;
endmodule

// File: rtl/irq_test_gen_chk.sv
module irq_test_gen_chk #(
  parameter int          AW      = 5,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_we,
  input logic [31:0]   req_wdata,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata,
  input logic          rsp_fault,
  input logic          irq_mext,
  input logic          irq_msw,
  input logic          irq_sext,
  input logic          irq_ssw
);
  wire [3:0] irqs = {irq_mext, irq_sext, irq_msw, irq_ssw};
  wire word_req = req_valid && req_size == 2'd2 && req_addr[1:0] == 2'b00;

  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(irqs)));
  a_r8_reserved_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == 4 && (req_wdata & 32'h7FFF_F5F5) != 0)
    |=> (rsp_fault && $stable(irqs)));
  a_r9_bad_size_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |=> (rsp_fault && $stable(irqs)));
  a_r10_misaligned_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_fault && $stable(irqs)));
  a_r11_upper_window_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= 8) |=> (rsp_fault && rsp_rdata == 32'h0));
  a_r2_version_read: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !req_we && req_addr == 0) |=> (!rsp_fault && rsp_rdata == VERSION));
  a_r5_raise_mext: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && req_we && req_addr == 4 && (req_wdata & 32'h7FFF_F5F5) == 0
     && req_wdata[31] && req_wdata[11]) |=> irq_mext);
  a_r6_drop_ssw: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && req_we && req_addr == 4 && (req_wdata & 32'h7FFF_F5F5) == 0
     && !req_wdata[31] && req_wdata[1]) |=> !irq_ssw);
endmodule

bind irq_test_gen irq_test_gen_chk #(.AW(AW), .VERSION(VERSION)) u_chk (.*);

// File: tb/sim_irq_test_gen.sv
module sim_irq_test_gen;
  localparam logic [31:0] VER = 32'h0001_0000;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [4:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [1:0] req_size = 0;
  logic rsp_valid, rsp_fault, irq_mext, irq_msw, irq_sext, irq_ssw;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  logic [3:0] model = 0;
  logic got_f;
  logic [31:0] got_d;

  always #10 clk = ~clk;

  irq_test_gen u0 (.*);

  wire [3:0] lines = {irq_mext, irq_sext, irq_msw, irq_ssw};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [4:0] a, input logic we, input logic [31:0] d, input logic [1:0] sz);
    req_valid = 1; req_addr = a; req_we = we; req_wdata = d; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    got_f = rsp_fault; got_d = rsp_rdata;
    chk("R12 rsp_valid", {31'h0, rsp_valid}, 32'h1);
  endtask

  function automatic logic [3:0] selof(input logic [31:0] d);
    return {d[11], d[9], d[3], d[1]};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {28'h0, lines}, 32'h0);
    chk("R1 reset valid", {30'h0, rsp_valid, rsp_fault}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    access(0, 0, 0, 2);
    chk("R2 version data", got_d, VER);
    chk("R2 version fault", {31'h0, got_f}, 0);
    access(4, 0, 0, 2);
    chk("R3 ctrl reads zero", got_d, 0);
    chk("R3 ctrl fault", {31'h0, got_f}, 0);

    // R5 R6 R7: every select group in both directions
    for (int i = 0; i < 32; i++) begin
      logic [3:0] s;
      logic [31:0] d;
      s = i[3:0] ^ i[4:1];
      d = {i[4], 19'h0, s[3], 1'b0, s[2], 5'h0, s[1], 1'b0, s[0], 1'b0};
      model = d[31] ? (model | s) : (model & ~s);
      access(4, 1, d, 2);
      chk(d[31] ? "R5 R7 raise" : "R6 R7 drop", {28'h0, lines}, {28'h0, model});
      chk("R5 no fault", {31'h0, got_f}, 0);
    end

    access(4, 1, 32'h8000_0A0A, 2); model = 4'hF;
    access(0, 1, 32'h0000_0A0A, 2);
    chk("R4 version write no fault", {31'h0, got_f}, 0);
    chk("R4 version write lines", {28'h0, lines}, {28'h0, model});
    access(4, 1, 32'h0000_0A0A, 2); model = 0;
    chk("R6 drop all", {28'h0, lines}, 0);

    // R8: every reserved bit
    for (int b = 0; b < 31; b++) begin
      if (b != 1 && b != 3 && b != 9 && b != 11) begin
        access(4, 1, 32'h8000_0A0A | (32'h1 << b), 2);
        chk("R8 reserved bit fault", {31'h0, got_f}, 1);
        chk("R8 reserved bit lines", {28'h0, lines}, {28'h0, model});
      end
    end

    // R9 R10 R11: every address and size, read then write
    for (int a = 0; a < 32; a++) begin
      for (int z = 0; z < 4; z++) begin
        logic ef;
        ef = (z != 2) || (a % 4 != 0) || (a >= 8);
        access(a[4:0], 0, 0, z[1:0]);
        chk(a >= 8 ? "R11 read fault" : (z != 2 ? "R9 read fault" : "R10 read fault"),
            {31'h0, got_f}, {31'h0, ef});
        chk("R11 read data", got_d, (!ef && a == 0) ? VER : 0);
        access(a[4:0], 1, 32'h8000_0A0A, z[1:0]);
        if (!ef && a == 4) model = 4'hF;
        chk(a >= 8 ? "R11 write lines" : (z != 2 ? "R9 write lines" : "R10 write lines"),
            {28'h0, lines}, {28'h0, model});
        chk("R9 R10 R11 write fault", {31'h0, got_f}, {31'h0, ef});
        if (!ef && a == 4) begin
          access(4, 1, 32'h0000_0208, 2); model = model & ~selof(32'h208);
        end
      end
    end

    @(negedge clk);
    chk("R12 idle no response", {31'h0, rsp_valid}, 0);
    chk("R12 idle lines", {28'h0, lines}, {28'h0, model});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule